// File: doc/BRIEF.md
# Trace-Mode Sampling Counter Engine

This block is a per-thread performance sampling engine. Software programs it through two 64-bit words: a control word that holds the enable, the mode, a 3-bit scope tag and an 8 KiB-aligned memory base address, and a trace configuration word that holds the sampling period, the choice of sampled event, two event selects and a buffer size code. Both words use MSB-first bit numbering: bit 0 is `word[63]` and bit 63 is `word[0]`.

In trace mode a 32-bit counter is loaded with the period and steps up by one for each selected event. When it carries out of bit 31, the engine issues a 16-byte record to memory: the program counter seen in the overflow cycle, then the running total of sampled events. It then reloads the period. Records fill a linear buffer. Once the buffer is full, the engine stops sampling without raising any interrupt. In accumulation mode the engine instead keeps two 64-bit event totals and writes both to the base address at a fixed interval, so software can poll them.

Records leave through a 64-bit valid/ready write port, two beats per record. Counting pauses while a record is in flight.

Top module: `smp_trace_engine`

## Requirements
- R1: After synchronous reset, `mem_valid` and `buf_full` are low.
- R2: While the enable bit (control bit 0, `ctl_word[63]`) is clear, no write is started and event inputs have no effect.
- R3: Trace mode is selected by control bit 1 (`ctl_word[62]` = 1). The counter is loaded with the period field (config bits 2:33, `cfg_word[61:30]`) and adds one per sampled event. A sampled event that finds the counter at all ones causes a record and reloads the period.
- R4: The sampled event is chosen by config bits 0:1 (`cfg_word[63:62]`): 0 every enabled cycle, 1 `evt_in[sel_a]`, 2 `evt_in[sel_b]`, 3 either one. `sel_a` is config bits 34:40 (`cfg_word[29:23]`) and `sel_b` is config bits 41:47 (`cfg_word[22:16]`).
- R5: A trace record has two beats. The first is written at the current buffer address and carries `pc_in` as sampled in the overflow cycle. The second is written at that address plus 8 and carries the number of sampled events since enable, counting the one that overflowed.
- R6: The base address is control bits 8:50 (`ctl_word[55:13]`) placed at address bits 55:13, with all other address bits zero. Reserved control bits have no effect on any address.
- R7: The buffer address starts at the base address and advances by 16 bytes for each record.
- R8: The buffer holds 4096 << size code bytes, where the size code is config bits 48:50 (`cfg_word[15:13]`). After the record that fills the buffer, `buf_full` goes high and no further trace record is written.
- R9: Clearing the enable bit and then setting it again returns the buffer address to the base, clears `buf_full` and the event total, and reloads the period.
- R10: `mem_valid` stays high with stable address and data until `mem_ready` accepts the beat. Events that arrive while a record is in flight are not counted.
- R11: In accumulation mode (`ctl_word[62]` = 0), the interval counter advances once per enabled cycle with no write in flight. After every ACC_INTERVAL such cycles, the engine writes the count of `evt_in[sel_a]` to the base address and the count of `evt_in[sel_b]` to base+8. Both counts run from enable and cover all counting cycles before the flush cycle.
- R12: `mem_scope` carries control bits 4:6 (`ctl_word[59:57]`), captured when the record is started, on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 64 | Control word: enable, mode, scope, base address |
| cfg_word | input | 64 | Trace configuration: sample source, period, event selects, size code |
| evt_in | input | EVT_N | Event strobes, one per selectable event |
| pc_in | input | 64 | Program counter of the monitored thread |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_addr | output | 64 | Byte address of the beat |
| mem_wdata | output | 64 | Beat data |
| mem_scope | output | 3 | Scope tag carried with the beat |
| buf_full | output | 1 | Trace buffer has been filled |

## Verification
The bench targets the overflow boundary. A counter that triggers one event early or late would put the wrong PC and total into the records. It fills a whole 4 KiB buffer and then drives one more event. A design with an off-by-one end check would write one record past the buffer end, or stop one record short. It stalls `mem_ready` while events arrive, so a design that kept counting during a record would report an inflated total in the next record. It also restarts after the buffer fills, to catch a pointer or full flag that survives the enable toggle. Finally, it compares the accumulation flush values against the exact number of counting cycles. This catches an engine that counts during its own flush or that loses cycles at the interval boundary.

// File: rtl/smp_pkg.sv
package smp_pkg;

    localparam int WORD_W = 64;
    localparam int PER_W  = 32;
    localparam int ESEL_W = 7;
    localparam int OFS_W  = 20;

    // Control word positions (hardware index = 63 - MSB-first index)
    localparam int CTL_EN_B     = 63;
    localparam int CTL_TRACE_B  = 62;
    localparam int CTL_SCOPE_HI = 59;
    localparam int CTL_SCOPE_LO = 57;
    localparam int CTL_ADDR_HI  = 55;
    localparam int CTL_ADDR_LO  = 13;

    // Trace configuration positions
    localparam int CFG_SRC_HI   = 63;
    localparam int CFG_SRC_LO   = 62;
    localparam int CFG_PER_HI   = 61;
    localparam int CFG_PER_LO   = 30;
    localparam int CFG_SELA_HI  = 29;
    localparam int CFG_SELA_LO  = 23;
    localparam int CFG_SELB_HI  = 22;
    localparam int CFG_SELB_LO  = 16;
    localparam int CFG_SIZE_HI  = 15;
    localparam int CFG_SIZE_LO  = 13;

    localparam int REC_BYTES = 16;

    typedef enum logic [1:0] {
        SMP_CYCLES  = 2'd0,
        SMP_EVT_A   = 2'd1,
        SMP_EVT_B   = 2'd2,
        SMP_EVT_ANY = 2'd3
    } smp_src_e;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_BEAT0 = 2'd1,
        WR_BEAT1 = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic              en;
        logic              trace;
        logic [2:0]        scope;
        logic [WORD_W-1:0] base;
    } ctl_t;

    typedef struct packed {
        smp_src_e          src;
        logic [PER_W-1:0]  period;
        logic [ESEL_W-1:0] sel_a;
        logic [ESEL_W-1:0] sel_b;
        logic [2:0]        size_code;
    } cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data0;
        logic [WORD_W-1:0] data1;
        logic [2:0]        scope;
    } rec_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.en    = w[CTL_EN_B];
        c.trace = w[CTL_TRACE_B];
        c.scope = w[CTL_SCOPE_HI:CTL_SCOPE_LO];
        c.base  = {8'h00, w[CTL_ADDR_HI:CTL_ADDR_LO], 13'h0000};
        return c;
    endfunction

    function automatic cfg_t decode_cfg(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.src       = smp_src_e'(w[CFG_SRC_HI:CFG_SRC_LO]);
        c.period    = w[CFG_PER_HI:CFG_PER_LO];
        c.sel_a     = w[CFG_SELA_HI:CFG_SELA_LO];
        c.sel_b     = w[CFG_SELB_HI:CFG_SELB_LO];
        c.size_code = w[CFG_SIZE_HI:CFG_SIZE_LO];
        return c;
    endfunction

    function automatic logic [OFS_W-1:0] buf_bytes(input logic [2:0] code);
        return OFS_W'(4096) << code;
    endfunction

endpackage

// File: rtl/smp_evt_select.sv
module smp_evt_select
    import smp_pkg::*;
#(
    parameter int EVT_N = 128,
    parameter int SEL_W = 7
) (
    input  logic [EVT_N-1:0] evt,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  smp_src_e         src,
    output logic             hit_a,
    output logic             hit_b,
    output logic             hit_smp
);
    localparam int PAD_N = 1 << SEL_W;

    logic [PAD_N-1:0] evt_pad;

    // Selects beyond the implemented event count read as zero
    for (genvar i = 0; i < PAD_N; i++) begin : g_pad
        if (i < EVT_N) begin : g_live
            assign evt_pad[i] = evt[i];
        end else begin : g_tie
            assign evt_pad[i] = 1'b0;
        end
    end

    assign hit_a = evt_pad[sel_a];
    assign hit_b = evt_pad[sel_b];

    always_comb begin
        unique case (src)
            SMP_CYCLES:  hit_smp = 1'b1;
            SMP_EVT_A:   hit_smp = hit_a;
            SMP_EVT_B:   hit_smp = hit_b;
            default:     hit_smp = hit_a | hit_b;
        endcase
    end
endmodule

// File: rtl/smp_period_ctr.sv
module smp_period_ctr #(
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic             tick,
    output logic             ovf
);
    logic [PER_W-1:0] cnt_q;

    // Carry out of the top bit on this tick
    assign ovf = tick && (cnt_q == {PER_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load || ovf) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/smp_acc_bank.sv
module smp_acc_bank #(
    parameter int N_CTR = 2,
    parameter int CW    = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      tick,
    input  logic [N_CTR-1:0]          hits,
    output logic [N_CTR-1:0][CW-1:0]  counts
);
    for (genvar k = 0; k < N_CTR; k++) begin : g_ctr
        logic [CW-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                val_q <= '0;
            end else if (tick && hits[k]) begin
                val_q <= val_q + 1'b1;
            end
        end

        assign counts[k] = val_q;
    end
endmodule

// File: rtl/smp_wr_seq.sv
module smp_wr_seq
    import smp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  rec_t              rec_in,
    output logic              busy,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [2:0]        mem_scope
);
    wr_state_e state_q;
    rec_t      rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            rec_q   <= '0;
        end else begin
            unique case (state_q)
                WR_IDLE: begin
                    if (launch) begin
                        rec_q   <= rec_in;
                        state_q <= WR_BEAT0;
                    end
                end
                WR_BEAT0: begin
                    if (mem_ready) state_q <= WR_BEAT1;
                end
                WR_BEAT1: begin
                    if (mem_ready) state_q <= WR_IDLE;
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != WR_IDLE);
    assign mem_valid = busy;
    assign mem_addr  = (state_q == WR_BEAT1) ? (rec_q.addr | WORD_W'(8)) : rec_q.addr;
    assign mem_wdata = (state_q == WR_BEAT1) ? rec_q.data1 : rec_q.data0;
    assign mem_scope = rec_q.scope;
endmodule

// File: rtl/smp_trace_engine.sv
module smp_trace_engine
    import smp_pkg::*;
#(
    parameter int EVT_N        = 128,
    parameter int ACC_INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       ctl_word,
    input  logic [63:0]       cfg_word,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic [63:0]       pc_in,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [63:0]       mem_addr,
    output logic [63:0]       mem_wdata,
    output logic [2:0]        mem_scope,
    output logic              buf_full
);
    localparam int IVL_W = (ACC_INTERVAL > 1) ? $clog2(ACC_INTERVAL) : 1;

    ctl_t ctl;
    cfg_t cfg;
    assign ctl = decode_ctl(ctl_word);
    assign cfg = decode_cfg(cfg_word);

    // Enable edge detection for restart
    logic en_q;
    logic en_rise;
    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ctl.en;
    end
    assign en_rise = ctl.en && !en_q;

    // Event selection
    logic hit_a, hit_b, hit_smp;
    smp_evt_select #(.EVT_N(EVT_N), .SEL_W(ESEL_W)) u_sel (
        .evt     (evt_in),
        .sel_a   (cfg.sel_a),
        .sel_b   (cfg.sel_b),
        .src     (cfg.src),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .hit_smp (hit_smp)
    );

    logic busy;
    logic full_q;

    // Trace path
    logic trace_tick, trace_ovf;
    assign trace_tick = ctl.en && ctl.trace && !busy && !full_q && !en_rise && hit_smp;

    smp_period_ctr #(.PER_W(PER_W)) u_per (
        .clk      (clk),
        .rst      (rst),
        .load     (en_rise),
        .load_val (cfg.period),
        .tick     (trace_tick),
        .ovf      (trace_ovf)
    );

    logic [WORD_W-1:0] total_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [OFS_W-1:0]  ptr_nxt;
    assign ptr_nxt = ptr_q + OFS_W'(REC_BYTES);

    always_ff @(posedge clk) begin
        if (rst || en_rise) begin
            total_q <= '0;
            ptr_q   <= '0;
            full_q  <= 1'b0;
        end else begin
            if (trace_tick) total_q <= total_q + 1'b1;
            if (trace_ovf) begin
                ptr_q  <= ptr_nxt;
                full_q <= (ptr_nxt == buf_bytes(cfg.size_code));
            end
        end
    end

    // Accumulation path
    logic             acc_tick, acc_flush;
    logic [IVL_W-1:0] ivl_q;
    logic [1:0][WORD_W-1:0] acc_cnt;

    assign acc_tick  = ctl.en && !ctl.trace && !busy && !en_rise;
    assign acc_flush = acc_tick && (ivl_q == IVL_W'(ACC_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || en_rise) begin
            ivl_q <= '0;
        end else if (acc_flush) begin
            ivl_q <= '0;
        end else if (acc_tick) begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    smp_acc_bank #(.N_CTR(2), .CW(WORD_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (en_rise),
        .tick   (acc_tick),
        .hits   ({hit_b, hit_a}),
        .counts (acc_cnt)
    );

    // Record assembly
    rec_t rec;
    always_comb begin
        rec.scope = ctl.scope;
        if (trace_ovf) begin
            rec.addr  = ctl.base + WORD_W'(ptr_q);
            rec.data0 = pc_in;
            rec.data1 = total_q + 1'b1;
        end else begin
            rec.addr  = ctl.base;
            rec.data0 = acc_cnt[0];
            rec.data1 = acc_cnt[1];
        end
    end

    smp_wr_seq u_wr (
        .clk       (clk),
        .rst       (rst),
        .launch    (trace_ovf || acc_flush),
        .rec_in    (rec),
        .busy      (busy),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_scope (mem_scope)
    );

    assign buf_full = full_q;
endmodule

// File: rtl/smp_trace_engine_chk.sv
module smp_trace_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_en,
    input logic        ctl_trace,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [63:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        buf_full
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!mem_valid && !buf_full));

    a_r2_no_start_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !mem_valid) |=> !mem_valid);

    a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    a_r5_second_beat_follows: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_addr[3]) |=> (mem_valid && mem_addr[3]));

    a_r7_beat_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[2:0] == 3'b000));

    a_r8_full_stays_quiet: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !mem_valid && ctl_trace) |=> !mem_valid);
endmodule

bind smp_trace_engine smp_trace_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_en    (ctl_word[63]),
    .ctl_trace (ctl_word[62]),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .buf_full  (buf_full)
);

// File: tb/smp_trace_engine_tb.sv
`timescale 1ns/100ps
module smp_trace_engine_tb;
    localparam int EVT_N = 128;
    localparam int ACC_N = 64;
    localparam logic [42:0] BASE_FLD = 43'h123;
    localparam logic [63:0] BASE = {8'h00, BASE_FLD, 13'h0000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [63:0] ctl_word = '0;
    logic [63:0] cfg_word = '0;
    logic [EVT_N-1:0] evt_in = '0;
    logic [63:0] pc_in = '0;
    logic mem_ready = 1'b1;
    logic mem_valid;
    logic [63:0] mem_addr, mem_wdata;
    logic [2:0] mem_scope;
    logic buf_full;

    always #2.5 clk = ~clk;

    smp_trace_engine #(.EVT_N(EVT_N), .ACC_INTERVAL(ACC_N)) u_dut (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .cfg_word(cfg_word),
        .evt_in(evt_in), .pc_in(pc_in), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_scope(mem_scope), .buf_full(buf_full)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Beat log, filled one half-cycle before each accepting edge
    logic [63:0] log_addr [2048];
    logic [63:0] log_data [2048];
    logic [2:0]  log_scope[2048];
    int n_beats = 0;

    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready && n_beats < 2048) begin
            log_addr[n_beats]  = mem_addr;
            log_data[n_beats]  = mem_wdata;
            log_scope[n_beats] = mem_scope;
            n_beats = n_beats + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] mk_ctl(input logic en, input logic trace, input logic [2:0] scope);
        logic [63:0] w;
        w = '0;
        w[63] = en; w[62] = trace; w[61:60] = 2'b11; w[59:57] = scope;
        w[56] = 1'b1; w[55:13] = BASE_FLD; w[12:0] = '1;
        return w;
    endfunction

    function automatic logic [63:0] mk_cfg(input logic [1:0] src, input logic [31:0] per,
                                           input logic [6:0] sa, input logic [6:0] sb,
                                           input logic [2:0] size);
        logic [63:0] w;
        w = '0;
        w[63:62] = src; w[61:30] = per; w[29:23] = sa; w[22:16] = sb;
        w[15:13] = size; w[12:0] = '1;
        return w;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic restart(input logic trace, input logic [2:0] scope);
        @(posedge clk); #1;
        ctl_word = mk_ctl(1'b0, trace, scope);
        cycles(2);
        ctl_word = mk_ctl(1'b1, trace, scope);
        cycles(2);
    endtask

    task automatic pulse(input int bitn, input logic [63:0] pc);
        @(posedge clk); #1;
        evt_in[bitn] = 1'b1; pc_in = pc;
        @(posedge clk); #1;
        evt_in[bitn] = 1'b0;
        cycles(4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid after reset", {63'd0, mem_valid}, 64'd0);
        check("R1 full after reset", {63'd0, buf_full}, 64'd0);
    endtask

    task automatic t_disabled();
        int b0;
        cfg_word = mk_cfg(2'd1, 32'hFFFF_FFFF, 7'd5, 7'd9, 3'd0);
        ctl_word = mk_ctl(1'b0, 1'b1, 3'd5);
        b0 = n_beats;
        for (int i = 0; i < 5; i++) pulse(5, 64'h10 + 64'(i));
        check("R2 no beats while disabled", 64'(n_beats - b0), 64'd0);
    endtask

    task automatic t_trace_basic();
        int b0;
        cfg_word = mk_cfg(2'd1, 32'hFFFF_FFFD, 7'd5, 7'd9, 3'd0);
        restart(1'b1, 3'd5);
        b0 = n_beats;
        for (int i = 1; i <= 6; i++) pulse(5, 64'h1000 + 64'(i));
        check("R3 two records from six events", 64'(n_beats - b0), 64'd4);
        check("R5 R6 first pc addr", log_addr[b0], BASE);
        check("R5 first pc at third event", log_data[b0], 64'h1003);
        check("R5 second beat addr", log_addr[b0+1], BASE + 64'd8);
        check("R5 first total", log_data[b0+1], 64'd3);
        check("R7 second record addr", log_addr[b0+2], BASE + 64'd16);
        check("R5 second pc", log_data[b0+2], 64'h1006);
        check("R5 second total", log_data[b0+3], 64'd6);
        check("R12 scope on beats", {61'd0, log_scope[b0+3]}, 64'd5);
    endtask

    task automatic t_src_select();
        int b0;
        cfg_word = mk_cfg(2'd2, 32'hFFFF_FFFF, 7'd5, 7'd9, 3'd0);
        restart(1'b1, 3'd2);
        b0 = n_beats;
        pulse(5, 64'h2000);
        check("R4 sel_a ignored with source 2", 64'(n_beats - b0), 64'd0);
        pulse(9, 64'h2001);
        check("R4 sel_b record count", 64'(n_beats - b0), 64'd2);
        check("R4 sel_b record pc", log_data[b0], 64'h2001);
        cfg_word = mk_cfg(2'd3, 32'hFFFF_FFFF, 7'd5, 7'd9, 3'd0);
        restart(1'b1, 3'd2);
        b0 = n_beats;
        pulse(5, 64'h2100);
        pulse(9, 64'h2101);
        check("R4 either source record count", 64'(n_beats - b0), 64'd4);
        check("R4 either source total", log_data[b0+3], 64'd2);
        cfg_word = mk_cfg(2'd0, 32'hFFFF_FFF0, 7'd5, 7'd9, 3'd0);
        pc_in = 64'h3000;
        @(posedge clk); #1;
        ctl_word = mk_ctl(1'b0, 1'b1, 3'd2);
        cycles(2);
        b0 = n_beats;
        ctl_word = mk_ctl(1'b1, 1'b1, 3'd2);
        cycles(22);
        check("R4 cycle source pc", log_data[b0], 64'h3000);
        check("R3 cycle source total after period", log_data[b0+1], 64'd16);
        ctl_word = mk_ctl(1'b0, 1'b1, 3'd2);
        cycles(4);
    endtask

    task automatic t_backpressure();
        int b0;
        logic [63:0] a_hold;
        cfg_word = mk_cfg(2'd1, 32'hFFFF_FFFF, 7'd5, 7'd9, 3'd0);
        mem_ready = 1'b0;
        restart(1'b1, 3'd1);
        b0 = n_beats;
        pulse(5, 64'h4000);
        @(negedge clk);
        a_hold = mem_addr;
        check("R10 valid held under stall", {63'd0, mem_valid}, 64'd1);
        pulse(5, 64'h4001);
        pulse(5, 64'h4002);
        @(negedge clk);
        check("R10 valid still held", {63'd0, mem_valid}, 64'd1);
        check("R10 addr stable under stall", mem_addr, a_hold);
        @(posedge clk); #1;
        mem_ready = 1'b1;
        cycles(4);
        pulse(5, 64'h4003);
        check("R10 records after stall", 64'(n_beats - b0), 64'd4);
        check("R10 stalled record pc", log_data[b0], 64'h4000);
        check("R10 events during stall not counted", log_data[b0+3], 64'd2);
    endtask

    task automatic t_full();
        int b0, b1;
        cfg_word = mk_cfg(2'd1, 32'hFFFF_FFFF, 7'd5, 7'd9, 3'd0);
        restart(1'b1, 3'd3);
        b0 = n_beats;
        for (int i = 0; i < 255; i++) pulse(5, 64'(i));
        check("R8 not full one record early", {63'd0, buf_full}, 64'd0);
        pulse(5, 64'd255);
        check("R8 records fill 4 KiB", 64'(n_beats - b0), 64'd512);
        check("R8 last record addr", log_addr[b0+510], BASE + 64'hFF0);
        check("R8 full flag", {63'd0, buf_full}, 64'd1);
        b1 = n_beats;
        pulse(5, 64'hDEAD);
        pulse(5, 64'hBEEF);
        check("R8 no record past end", 64'(n_beats - b1), 64'd0);
        restart(1'b1, 3'd3);
        check("R9 full cleared by restart", {63'd0, buf_full}, 64'd0);
        b1 = n_beats;
        pulse(5, 64'h5000);
        check("R9 record after restart", 64'(n_beats - b1), 64'd2);
        check("R9 pointer back at base", log_addr[b1], BASE);
        check("R9 total restarted", log_data[b1+1], 64'd1);
    endtask

    task automatic t_acc();
        int b0;
        cfg_word = mk_cfg(2'd0, 32'h0, 7'd3, 7'd4, 3'd0);
        evt_in[3] = 1'b1;
        @(posedge clk); #1;
        ctl_word = mk_ctl(1'b0, 1'b0, 3'd6);
        cycles(2);
        b0 = n_beats;
        ctl_word = mk_ctl(1'b1, 1'b0, 3'd6);
        cycles(2 * ACC_N + 12);
        check("R11 first flush addr", log_addr[b0], BASE);
        check("R11 first flush count a", log_data[b0], 64'(ACC_N - 1));
        check("R11 first flush count b addr", log_addr[b0+1], BASE + 64'd8);
        check("R11 first flush count b", log_data[b0+1], 64'd0);
        check("R11 second flush addr", log_addr[b0+2], BASE);
        check("R11 second flush count a", log_data[b0+2], 64'(2 * ACC_N - 1));
        check("R12 scope in accumulation", {61'd0, log_scope[b0]}, 64'd6);
        ctl_word = mk_ctl(1'b0, 1'b0, 3'd6);
        evt_in[3] = 1'b0;
        cycles(4);
    endtask

    initial begin
        cycles(4);
        t_reset();
        @(posedge clk); #1;
        rst = 1'b0;
        cycles(2);
        t_disabled();
        t_trace_basic();
        t_src_select();
        t_backpressure();
        t_full();
        t_acc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule